// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block turns the addressing part of an opcode for an 8-bit accumulator machine into a 16-bit memory address. The upper four bits of the opcode pick the addressing mode. A prefix flag moves the offset-indexed modes from the H:X index pair onto the stack pointer. The block takes up to two extension bytes that follow the opcode, the 16-bit index pair and the 16-bit stack pointer. It returns three things: the effective address, how many extension bytes the mode consumes, and a flag for nibbles that name no memory mode.

The address is worked out combinationally in a single cycle. It is captured in an output register when the input strobe is high, and it is held while the strobe is low. The instruction sequencer presents one decode per strobe and reads the result one clock edge later.

Top module: `idx_ea_unit`

## Requirements
- R1: Upper opcode nibbles 0x0, 0x1, 0x3 and 0xB give direct mode. The address is the first extension byte with its upper 8 bits zero, the byte count is 1, and the prefix has no effect.
- R2: Upper nibbles 0x7 and 0xF give no-offset indexed mode. The address is the index pair, the byte count is 0, and the prefix has no effect.
- R3: Upper nibbles 0x6 and 0xE add the first extension byte, taken as unsigned, to a base. The base is the index pair when the prefix is 0 and the stack pointer when the prefix is 1. The byte count is 1.
- R4: Upper nibble 0xD adds a 16-bit offset to the same base as R3. The first extension byte is the high byte of the offset and the second is the low byte. The byte count is 2.
- R5: Upper nibble 0xC gives extended mode. The address is the first extension byte as the high byte and the second as the low byte, the byte count is 2, and the prefix has no effect.
- R6: Upper nibbles 0x2, 0x4, 0x5, 0x8, 0x9 and 0xA raise the invalid flag and give address 0 and byte count 0. Every other nibble leaves the flag at 0.
- R7: Every address sum wraps modulo 2^16.
- R8: The outputs take the result of the inputs presented in a cycle where the strobe is high, at that rising clock edge. While the strobe is low they hold, whatever the other inputs do.
- R9: When the active-low reset is low at a rising edge, the address, the byte count and the invalid flag become 0.
- R10: The lower opcode nibble has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe that captures a new decode |
| opcode | input | 8 | Opcode byte; the upper nibble selects the mode |
| prefix_en | input | 1 | Prefix present: offset modes use the stack pointer |
| ext_b0 | input | 8 | First extension byte after the opcode |
| ext_b1 | input | 8 | Second extension byte after the opcode |
| idx_pair | input | 16 | Index pair, H in the upper byte |
| stk_ptr | input | 16 | Stack pointer |
| ea_out | output | 16 | Registered effective address |
| ext_cnt | output | 2 | Registered number of extension bytes consumed |
| mode_bad | output | 1 | Registered flag: the nibble names no memory mode |

## Verification
The hardest case to reach is an offset-indexed sum that carries out of bit 15 while the prefix is set. It needs a stack pointer near the top of the address space and an offset chosen so that the carry crosses the byte boundary. The stimulus places the stack pointer and the index pair at chosen values near 0xFFFF, with 8-bit and 16-bit offsets that push the sum past the wrap. It also gives the two bases different values, so that picking the wrong base shows up in the address. Hold behaviour is checked by changing every data input during strobe-low cycles and then comparing the outputs with the last captured result.

// File: rtl/ea_pkg.sv
// Shared types for the effective address generator.
// Assumes the address is twice the byte width.
package ea_pkg;
    typedef enum logic [2:0] {
        AM_NONE  = 3'd0,
        AM_DIR   = 3'd1,
        AM_IX0   = 3'd2,
        AM_IX8   = 3'd3,
        AM_IX16  = 3'd4,
        AM_EXT   = 3'd5
    } amode_t;
endpackage

// File: rtl/ea_mode_dec.sv
// Mode decoder: maps the upper opcode nibble to an addressing mode,
// an extension byte count and an invalid flag. Purely combinational.
// Assumes the caller passes only the upper nibble.
module ea_mode_dec
    import ea_pkg::*;
(
    input  logic [3:0] nib,
    output amode_t     mode,
    output logic [1:0] nbytes,
    output logic       bad
);
    // Classify the nibble into a mode.
    always_comb begin
        unique case (nib)
            4'h0, 4'h1, 4'h3, 4'hB: mode = AM_DIR;
            4'h7, 4'hF:             mode = AM_IX0;
            4'h6, 4'hE:             mode = AM_IX8;
            4'hD:                   mode = AM_IX16;
            4'hC:                   mode = AM_EXT;
            default:                mode = AM_NONE;
        endcase
    end

    // Derive byte count and invalid flag from the mode.
    always_comb begin
        bad = 1'b0;
        unique case (mode)
            AM_DIR, AM_IX8:   nbytes = 2'd1;
            AM_IX16, AM_EXT:  nbytes = 2'd2;
            AM_IX0:           nbytes = 2'd0;
            default: begin
                nbytes = 2'd0;
                bad    = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ea_addr_calc.sv
// Address datapath: selects the base (index pair or stack pointer) and
// the offset for the decoded mode, and forms the address with a
// wrapping adder. Combinational; assumes AW == 2*DW.
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  amode_t          mode,
    input  logic            prefix_en,
    input  logic [DW-1:0]   ext_b0,
    input  logic [DW-1:0]   ext_b1,
    input  logic [AW-1:0]   idx_pair,
    input  logic [AW-1:0]   stk_ptr,
    output logic [AW-1:0]   ea
);
    logic [AW-1:0] base;
    logic [AW-1:0] ofs8;
    logic [AW-1:0] ofs16;
    logic [AW-1:0] sum;

    // Base pick: the prefix moves offset modes onto the stack pointer.
    always_comb base = prefix_en ? stk_ptr : idx_pair;

    // Offset operands in both widths.
    always_comb begin
        ofs8  = {{DW{1'b0}}, ext_b0};
        ofs16 = {ext_b0, ext_b1};
    end

    // Single shared adder; carry out of the top bit is dropped.
    always_comb sum = base + ((mode == AM_IX16) ? ofs16 : ofs8);

    // Final address mux per mode.
    always_comb begin
        unique case (mode)
            AM_DIR:           ea = ofs8;
            AM_IX0:           ea = idx_pair;
            AM_IX8, AM_IX16:  ea = sum;
            AM_EXT:           ea = ofs16;
            default:          ea = '0;
        endcase
    end
endmodule

// File: rtl/ea_out_reg.sv
// Output stage: loads a new result on the strobe and holds it
// otherwise; synchronous active-low reset clears every field.
module ea_out_reg #(
    parameter int AW = 16,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ea_d,
    input  logic [CW-1:0] cnt_d,
    input  logic          bad_d,
    output logic [AW-1:0] ea_q,
    output logic [CW-1:0] cnt_q,
    output logic          bad_q
);
    // Capture or hold the result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q  <= '0;
            cnt_q <= '0;
            bad_q <= 1'b0;
        end else if (load) begin
            ea_q  <= ea_d;
            cnt_q <= cnt_d;
            bad_q <= bad_d;
        end
    end
endmodule

// File: rtl/idx_ea_unit.sv
// Top of the effective address generator: decodes the upper opcode
// nibble, forms the address, and registers it on in_valid.
// Assumes the extension bytes are presented together with the opcode.
module idx_ea_unit
    import ea_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW,
    localparam int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    opcode,
    input  logic          prefix_en,
    input  logic [DW-1:0] ext_b0,
    input  logic [DW-1:0] ext_b1,
    input  logic [AW-1:0] idx_pair,
    input  logic [AW-1:0] stk_ptr,
    output logic [AW-1:0] ea_out,
    output logic [CW-1:0] ext_cnt,
    output logic          mode_bad
);
    amode_t        mode;
    logic [CW-1:0] nbytes;
    logic          bad;
    logic [AW-1:0] ea_c;

    ea_mode_dec u_dec (
        .nib    (opcode[7:4]),
        .mode   (mode),
        .nbytes (nbytes),
        .bad    (bad)
    );

    ea_addr_calc #(.DW(DW)) u_calc (
        .mode      (mode),
        .prefix_en (prefix_en),
        .ext_b0    (ext_b0),
        .ext_b1    (ext_b1),
        .idx_pair  (idx_pair),
        .stk_ptr   (stk_ptr),
        .ea        (ea_c)
    );

    ea_out_reg #(.AW(AW), .CW(CW)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (in_valid),
        .ea_d  (ea_c),
        .cnt_d (nbytes),
        .bad_d (bad),
        .ea_q  (ea_out),
        .cnt_q (ext_cnt),
        .bad_q (mode_bad)
    );
endmodule

// File: rtl/idx_ea_unit_chk.sv
// Checker for idx_ea_unit: relates the registered outputs to the inputs
// of the previous cycle. Attached by the bind at the end of this file.
module idx_ea_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [7:0]  opcode,
    input logic [7:0]  ext_b0,
    input logic [7:0]  ext_b1,
    input logic [15:0] idx_pair,
    input logic [15:0] ea_out,
    input logic [1:0]  ext_cnt,
    input logic        mode_bad
);
    // R9: reset clears all outputs
    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (ea_out == 16'h0 && ext_cnt == 2'd0 && !mode_bad));

    // R8: outputs hold while the strobe is low
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(ea_out) && $stable(ext_cnt) && $stable(mode_bad)));

    // R6: invalid result carries zero address and zero count
    a_r6_bad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bad |-> (ea_out == 16'h0 && ext_cnt == 2'd0));

    // R2: no-offset mode returns the index pair
    a_r2_no_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[6:4] == 3'b111) |=>
            (ea_out == $past(idx_pair) && ext_cnt == 2'd0 && !mode_bad));

    // R5: extended mode joins the two extension bytes
    a_r5_extended: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode[7:4] == 4'hC) |=>
            (ea_out == {$past(ext_b0), $past(ext_b1)} && ext_cnt == 2'd2));

    // R1: direct mode zero-extends the first extension byte
    a_r1_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opcode[7:4] == 4'h0 || opcode[7:4] == 4'h1 ||
                      opcode[7:4] == 4'h3 || opcode[7:4] == 4'hB)) |=>
            (ea_out == {8'h00, $past(ext_b0)} && ext_cnt == 2'd1));
endmodule

bind idx_ea_unit idx_ea_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .opcode   (opcode),
    .ext_b0   (ext_b0),
    .ext_b1   (ext_b1),
    .idx_pair (idx_pair),
    .ea_out   (ea_out),
    .ext_cnt  (ext_cnt),
    .mode_bad (mode_bad)
);

// File: tb/test_idx_ea_unit.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops
// them one cycle after each strobe and compares.
module test_idx_ea_unit;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [15:0] ea;
        logic [1:0]  cnt;
        logic        bad;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic        prefix_en = 1'b0;
    logic [7:0]  ext_b0 = 8'h00;
    logic [7:0]  ext_b1 = 8'h00;
    logic [15:0] idx_pair = 16'h0000;
    logic [15:0] stk_ptr = 16'h0000;
    logic [15:0] ea_out;
    logic [1:0]  ext_cnt;
    logic        mode_bad;

    int total = 0;
    int bad = 0;
    exp_t sb[$];
    exp_t last_exp;
    logic fire_q = 1'b0;

    idx_ea_unit i_idx_ea_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .prefix_en(prefix_en), .ext_b0(ext_b0), .ext_b1(ext_b1),
        .idx_pair(idx_pair), .stk_ptr(stk_ptr), .ea_out(ea_out),
        .ext_cnt(ext_cnt), .mode_bad(mode_bad)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [7:0] op, input logic pf,
                                   input logic [7:0] b0, input logic [7:0] b1,
                                   input logic [15:0] hx, input logic [15:0] sp,
                                   input string tag);
        exp_t e;
        logic [15:0] base;
        base = pf ? sp : hx;
        e.tag = tag; e.bad = 1'b0;
        case (op[7:4])
            4'h0, 4'h1, 4'h3, 4'hB: begin e.ea = {8'h00, b0}; e.cnt = 2'd1; end
            4'h7, 4'hF:             begin e.ea = hx; e.cnt = 2'd0; end
            4'h6, 4'hE:             begin e.ea = 16'(base + {8'h00, b0}); e.cnt = 2'd1; end
            4'hD:                   begin e.ea = 16'(base + {b0, b1}); e.cnt = 2'd2; end
            4'hC:                   begin e.ea = {b0, b1}; e.cnt = 2'd2; end
            default:                begin e.ea = 16'h0; e.cnt = 2'd0; e.bad = 1'b1; end
        endcase
        return e;
    endfunction

    function automatic void compare(input exp_t e, input string what);
        total++;
        if (ea_out !== e.ea || ext_cnt !== e.cnt || mode_bad !== e.bad) begin
            bad++;
            $display("FAIL %s %s: got ea=%h cnt=%0d bad=%b exp ea=%h cnt=%0d bad=%b",
                     e.tag, what, ea_out, ext_cnt, mode_bad, e.ea, e.cnt, e.bad);
        end
    endfunction

    // Driver: one strobed decode, expected result pushed to the scoreboard.
    task automatic drive(input logic [7:0] op, input logic pf,
                         input logic [7:0] b0, input logic [7:0] b1,
                         input logic [15:0] hx, input logic [15:0] sp,
                         input string tag);
        @(negedge clk);
        opcode = op; prefix_en = pf; ext_b0 = b0; ext_b1 = b1;
        idx_pair = hx; stk_ptr = sp; in_valid = 1'b1;
        sb.push_back(model(op, pf, b0, b1, hx, sp, tag));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: note strobes at the edge, compare half a cycle later.
    always @(posedge clk) fire_q <= in_valid && rst_n;
    always @(negedge clk) begin
        if (fire_q) begin
            if (sb.size() == 0) begin
                total++; bad++;
                $display("FAIL R8: result with empty scoreboard");
            end else begin
                last_exp = sb.pop_front();
                compare(last_exp, "capture");
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 50000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        exp_t z;
        logic [15:0] lf;
        z.ea = 16'h0; z.cnt = 2'd0; z.bad = 1'b0; z.tag = "R9";
        repeat (3) @(negedge clk);
        compare(z, "reset state");
        rst_n = 1'b1;

        // R1 direct, prefix has no effect
        drive(8'h0A, 1'b0, 8'h5C, 8'h11, 16'h1234, 16'h8000, "R1");
        drive(8'hB7, 1'b1, 8'hFF, 8'h22, 16'h1234, 16'h8000, "R1");
        // R2 no-offset, prefix has no effect
        drive(8'h70, 1'b0, 8'h33, 8'h44, 16'hBEEF, 16'h0100, "R2");
        drive(8'hF3, 1'b1, 8'h33, 8'h44, 16'hBEEF, 16'h0100, "R2");
        // R3 8-bit offset on index pair and on stack pointer
        drive(8'h6B, 1'b0, 8'h80, 8'h00, 16'h1000, 16'h2000, "R3");
        drive(8'hE1, 1'b1, 8'h80, 8'h00, 16'h1000, 16'h2000, "R3");
        // R4 16-bit offset, byte order high then low
        drive(8'hD6, 1'b0, 8'h12, 8'h34, 16'h0100, 16'h0200, "R4");
        drive(8'hD6, 1'b1, 8'h12, 8'h34, 16'h0100, 16'h0200, "R4");
        // R5 extended, prefix has no effect
        drive(8'hC9, 1'b1, 8'hA5, 8'h5A, 16'h0001, 16'h0002, "R5");
        // R7 wrap-around on both bases and widths
        drive(8'hE0, 1'b1, 8'h10, 8'h00, 16'h0000, 16'hFFF8, "R7");
        drive(8'h60, 1'b0, 8'hFF, 8'h00, 16'hFF01, 16'h0000, "R7");
        drive(8'hD0, 1'b1, 8'h80, 8'h01, 16'h0000, 16'h8000, "R7");
        drive(8'hD0, 1'b0, 8'hFF, 8'hFF, 16'hFFFF, 16'h0000, "R7");
        // R6 every non-memory nibble, R10 low nibble swept through all nibbles
        for (int n = 0; n < 16; n++) begin
            for (int l = 0; l < 16; l += 5)
                drive({4'(n), 4'(l)}, 1'(l & 1), 8'(8'h3C + n), 8'(8'h91 ^ l),
                      16'(16'h4321 + n * 16'h0111), 16'(16'hF00F - l),
                      (n inside {2, 4, 5, 8, 9, 10}) ? "R6" : "R10");
        end

        // R8 hold: inputs change with strobe low
        drive(8'hD2, 1'b0, 8'h01, 8'h02, 16'h0300, 16'h0400, "R8");
        @(negedge clk);
        opcode = 8'hC0; prefix_en = 1'b1; ext_b0 = 8'hEE; ext_b1 = 8'hDD;
        idx_pair = 16'h7777; stk_ptr = 16'h6666;
        repeat (3) @(negedge clk);
        last_exp.tag = "R8";
        compare(last_exp, "hold");

        // Mixed vectors from an LFSR
        lf = 16'hACE1;
        for (int k = 0; k < 40; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            drive(lf[15:8], lf[0], lf[7:0], lf[11:4], {lf[7:0], lf[15:8]},
                  lf ^ 16'h5A5A, "R3");
        end

        // R9 reset mid-run after a non-zero result
        drive(8'hC0, 1'b0, 8'hAB, 8'hCD, 16'h0, 16'h0, "R5");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        compare(z, "mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule